// File: doc/BRIEF.md
# Secondary Processor Start Register

This block is a single word-wide status and control register for a small multiprocessor cluster. It lives in the register space of an interrupt controller. After reset only processor 0 runs, and every other processor is reported as powered down. Software wakes a secondary processor by writing a mask with a 1 in that processor's bit position. The block then raises that processor's start line and keeps it high until the next reset.

The read and write meanings of the per-processor bits are opposite. Writing 1 requests a start. Reading 1 reports that the processor has not been started yet. The top nibble of the word reports the processor count minus one. A neighbouring clear register in the same space always reads as zero. Reads go through a simple strobe: the data and a valid flag appear one cycle after the read strobe.

Top module: `cpu_start_ctrl`

## Requirements
- R1: Bits 31:28 of the status word always read as NUM_CPU-1, and writes never change them.
- R2: Reset is synchronous and active-high. It drives every start output low and reloads the status word. After reset, bits NUM_CPU-1..1 read 1 and bit 0 reads 0.
- R3: A write to the status offset with bit i set, for 1 <= i < NUM_CPU, raises cpu_start[i] at the next clock edge. From then on, status bit i reads 0.
- R4: Bit 0 is masked from writes. cpu_start[0] is always 0 and status bit 0 always reads 0.
- R5: Once a start output is high, it stays high until reset, whatever is written.
- R6: Writing 0 to a status bit leaves that bit and its start output unchanged.
- R7: Write bits at positions NUM_CPU and above are ignored. Status bits 27 down to NUM_CPU always read 0.
- R8: The clear register, at byte offset 0x0C, always reads 0, and a write to it changes no start output or status bit.
- R9: A write to any offset other than 0x10 leaves the start outputs and the status word unchanged. A read of an unmapped offset returns 0.
- R10: The status register sits at byte offset 0x10. A read strobe in cycle t gives rd_valid=1 and the data in cycle t+1. rd_valid is 0 in every cycle that does not follow a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Byte offset of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |
| cpu_start | output | NUM_CPU | Per-processor start lines, sticky high |

## Verification
The start logic is driven with several kinds of write mask:
- A mask with only bit 0 set. This tells a correct bit-0 mask apart from an unmasked one.
- An all-zero mask. This exposes a write that toggles or clears state instead of only setting it.
- A mask whose high bits lie beyond the processor count and inside the count field. This shows whether out-of-range bits leak into state or readback.
- A single-bit mask, and then a two-bit mask, with a zero write in between. These separate per-bit starting from sticky behaviour.

Writes to the clear offset and to an unmapped offset check the address decode. A second reset after some processors have started checks that the reset encoding is reloaded.

// File: rtl/cpu_start_pkg.sv
package cpu_start_pkg;
  localparam int WORD_W     = 32;
  localparam int NCPU_LSB   = 28;
  localparam int NCPU_W     = 4;
  localparam int MAX_CPU    = 16;
  localparam int DEF_ADDR_W = 8;
  localparam logic [DEF_ADDR_W-1:0] DEF_STATUS_OFS = 8'h10;
  localparam logic [DEF_ADDR_W-1:0] DEF_CLEAR_OFS  = 8'h0C;
endpackage

// File: rtl/cpu_start_decode.sv
module cpu_start_decode #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] STATUS_OFS = '0,
  parameter logic [ADDR_W-1:0] CLEAR_OFS  = '0
) (
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  output logic              wr_status,
  output logic              rd_status,
  output logic              rd_clear
);
  always_comb begin
    wr_status = wr_en && (addr == STATUS_OFS);
    rd_status = rd_en && (addr == STATUS_OFS);
    rd_clear  = rd_en && (addr == CLEAR_OFS);
  end
endmodule

// File: rtl/cpu_start_state.sv
module cpu_start_state #(
  parameter int NUM_CPU = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_status,
  input  logic [cpu_start_pkg::WORD_W-1:0] wdata,
  output logic [NUM_CPU-1:0]         start_q
);
  localparam logic [NUM_CPU-1:0] ALLOW = ~NUM_CPU'(1);

  logic [NUM_CPU-1:0] wr_bits;
  logic               unused_wdata;
  assign wr_bits      = wdata[NUM_CPU-1:0];
  assign unused_wdata = ^wdata;

  for (genvar i = 0; i < NUM_CPU; i++) begin : g_cpu
    if (i == 0) begin : g_boot
      assign start_q[i] = 1'b0;
    end else begin : g_sec
      always_ff @(posedge clk) begin
        if (rst)
          start_q[i] <= 1'b0;
        else if (wr_status && wr_bits[i])
          start_q[i] <= 1'b1;
      end
    end
  end

  AST_CPU0_IDLE: assert property (@(posedge clk) disable iff (rst)
    start_q[0] == 1'b0); // R4
  AST_START_STICKY: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((start_q & $past(start_q)) == $past(start_q))); // R5
  AST_WRITE_STARTS: assert property (@(posedge clk) disable iff (rst)
    ($past(wr_status) && !$past(rst)) |->
      ((start_q & $past(wr_bits) & ALLOW) == ($past(wr_bits) & ALLOW))); // R3
  AST_HOLD_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (rst)
    (!$past(wr_status) && !$past(rst)) |-> $stable(start_q)); // R9
endmodule

// File: rtl/cpu_start_readback.sv
module cpu_start_readback #(
  parameter int NUM_CPU = 4
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             rd_en,
  input  logic                             rd_status,
  input  logic                             rd_clear,
  input  logic [NUM_CPU-1:0]               start_q,
  output logic [cpu_start_pkg::WORD_W-1:0] rdata,
  output logic                             rd_valid
);
  import cpu_start_pkg::*;

  logic [WORD_W-1:0] status_word;

  always_comb begin
    status_word = '0;
    status_word[NCPU_LSB +: NCPU_W] = NCPU_W'(NUM_CPU - 1);
    for (int i = 1; i < NUM_CPU; i++)
      status_word[i] = ~start_q[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata    <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en)
        rdata <= rd_status ? status_word : '0;
    end
  end

  AST_NCPU_FIELD: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && $past(rd_status)) |-> (rdata[NCPU_LSB +: NCPU_W] == NCPU_W'(NUM_CPU - 1))); // R1
  AST_CLEAR_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && $past(rd_clear)) |-> (rdata == '0)); // R8
  AST_HIGH_BITS_ZERO: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> (rdata[NCPU_LSB-1:NUM_CPU] == '0)); // R7
  AST_VALID_TIMING: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (rd_valid == $past(rd_en))); // R10
endmodule

// File: rtl/cpu_start_ctrl.sv
module cpu_start_ctrl #(
  parameter int NUM_CPU = 4,
  parameter int ADDR_W  = cpu_start_pkg::DEF_ADDR_W,
  parameter logic [ADDR_W-1:0] STATUS_OFS = ADDR_W'(cpu_start_pkg::DEF_STATUS_OFS),
  parameter logic [ADDR_W-1:0] CLEAR_OFS  = ADDR_W'(cpu_start_pkg::DEF_CLEAR_OFS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              rd_valid,
  output logic [NUM_CPU-1:0] cpu_start
);
  initial begin
    if (NUM_CPU < 1 || NUM_CPU > cpu_start_pkg::MAX_CPU)
      $error("NUM_CPU out of range");
  end

  logic wr_status, rd_status, rd_clear;

  cpu_start_decode #(
    .ADDR_W(ADDR_W), .STATUS_OFS(STATUS_OFS), .CLEAR_OFS(CLEAR_OFS)
  ) u_decode (
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_status(wr_status), .rd_status(rd_status), .rd_clear(rd_clear)
  );

  cpu_start_state #(.NUM_CPU(NUM_CPU)) u_state (
    .clk(clk), .rst(rst), .wr_status(wr_status), .wdata(wdata),
    .start_q(cpu_start)
  );

  cpu_start_readback #(.NUM_CPU(NUM_CPU)) u_readback (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rd_status(rd_status),
    .rd_clear(rd_clear), .start_q(cpu_start), .rdata(rdata),
    .rd_valid(rd_valid)
  );
endmodule

// File: tb/test_cpu_start_ctrl.sv
module test_cpu_start_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NCPU = 4;
  localparam logic [7:0] OFS_STATUS = 8'h10;
  localparam logic [7:0] OFS_CLEAR  = 8'h0C;
  localparam logic [7:0] OFS_OTHER  = 8'h20;

  logic clk = 0, rst = 1, wr_en = 0, rd_en = 0;
  logic [7:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic rd_valid;
  logic [NCPU-1:0] cpu_start;

  int checks = 0, fails = 0;
  logic [NCPU-1:0] model_start = '0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  cpu_start_ctrl #(.NUM_CPU(NCPU)) i_cpu_start_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rd_valid(rd_valid), .cpu_start(cpu_start)
  );

  function automatic logic [31:0] exp_status();
    logic [31:0] w = '0;
    w[31:28] = 4'(NCPU - 1);
    for (int i = 1; i < NCPU; i++) w[i] = ~model_start[i];
    return w;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pops the expected read data whenever rd_valid is seen
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      if (exp_q.size() == 0) check("R10 unexpected rd_valid", 32'd1, 32'd0);
      else check(tag_q.pop_front(), rdata, exp_q.pop_front());
    end
  end

  task automatic do_write(input logic [7:0] a, input logic [31:0] d, input string req);
    @(negedge clk);
    wr_en = 1; addr = a; wdata = d;
    if (a == OFS_STATUS)
      for (int i = 1; i < NCPU; i++) if (d[i]) model_start[i] = 1'b1;
    @(negedge clk);
    wr_en = 0;
    check(req, 32'(cpu_start), 32'(model_start));
  endtask

  task automatic do_read(input logic [7:0] a, input string req);
    @(negedge clk);
    rd_en = 1; addr = a;
    exp_q.push_back(a == OFS_STATUS ? exp_status() : 32'd0);
    tag_q.push_back(req);
    @(negedge clk);
    rd_en = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1; model_start = '0;
    @(negedge clk); @(negedge clk);
    check("R2 starts low in reset", 32'(cpu_start), 32'd0);
    rst = 0;
  endtask

  initial begin
    fork
      begin
        do_reset();
        do_read(OFS_STATUS, "R2 R1 reset status word");
        do_read(OFS_CLEAR, "R8 clear reads zero");
        do_write(OFS_STATUS, 32'h1, "R4 bit0 masked start");
        do_read(OFS_STATUS, "R4 bit0 status");
        do_write(OFS_STATUS, 32'h0, "R6 zero write start");
        do_write(OFS_STATUS, 32'hFFFF_FFF0, "R7 high bits ignored start");
        do_read(OFS_STATUS, "R7 R1 high bits readback");
        do_write(OFS_CLEAR, 32'hF, "R8 clear write no effect");
        do_write(OFS_OTHER, 32'hF, "R9 other offset write");
        do_read(OFS_STATUS, "R9 status after foreign writes");
        do_write(OFS_STATUS, 32'h4, "R3 start cpu2");
        do_read(OFS_STATUS, "R3 status after cpu2");
        do_write(OFS_STATUS, 32'h0, "R5 R6 zero keeps start");
        do_write(OFS_STATUS, 32'hA, "R3 start cpu1 cpu3");
        do_read(OFS_STATUS, "R3 all started status");
        do_write(OFS_STATUS, 32'h0, "R5 sticky after all");
        do_read(OFS_OTHER, "R9 unmapped reads zero");
        @(negedge clk); @(negedge clk);
        check("R10 rd_valid idle low", 32'(rd_valid), 32'd0);
        do_reset();
        do_read(OFS_STATUS, "R2 status reloaded");
        @(negedge clk); @(negedge clk);
        check("R10 all reads returned", 32'(exp_q.size()), 32'd0);
      end
      begin
        repeat (10000) @(posedge clk);
        check("watchdog expired", 32'd1, 32'd0);
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule